// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Event Mode

This block is an 8-bit down-counting timer that a processor programs through a small register port. A control register picks the clock source for the counter. A 3-bit code selects one of seven prescaler divisors, or stops the counter. A mode bit makes the counter step on rising edges of an external event input instead. A third field holds the timer output low. A data register sets the value that the counter reloads. Reading the data register returns the live count.

Each time the counter steps away from 1, it reloads, raises a one-clock interrupt request and toggles its output. The external event input may be asynchronous, and it is synchronised inside the block. The asynchronous active-low reset is released synchronously inside the block.

Top module: `evt_prescale_timer`

## Requirements
- R1: After reset the control register reads 0x00, the count reads 0, and both `tmr_out` and `irq` are 0.
- R2: With the event bit clear, control bits [2:0] pick the step rate: code 0 holds the count, and codes 1 to 7 decrement it once every 4, 10, 16, 50, 64, 100 and 200 clocks.
- R3: With control bit 3 set, the count decrements once per rising edge of `ev_in` after a two-flop synchroniser, and the prescaler code has no effect on stepping.
- R4: While control bit 4 is set, `tmr_out` is 0. The toggle state keeps changing underneath, so on release `tmr_out` equals the parity of all underflows since reset.
- R5: A data write (`cpu_sel`=1) loads both the reload value and the count while the timer is stopped (code 0 and event bit clear). While the timer runs, a data write changes only the reload value.
- R6: A step taken from count 1 loads the reload value, drives `irq` high for exactly one clock, and toggles the output state.
- R7: A reload value of 0 gives a period of 256 steps.
- R8: A control write that changes the code restarts the prescaler. The first step at the new rate comes one full new period after that write.
- R9: A read with `cpu_sel`=0 returns the control register in bits [4:0] with bits [7:5] as zero; written upper bits are dropped. A read with `cpu_sel`=1 returns the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe, one clock per write |
| cpu_sel | input | 1 | Register select: 0 control, 1 data |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| ev_in | input | 1 | External event input, may be asynchronous |
| irq | output | 1 | One-clock underflow interrupt request |
| tmr_out | output | 1 | Timer output, toggles on underflow |

## Verification
The assertions assume that the count changes only through a data write, a single decrement or an underflow reload. They also assume that two underflows never come in consecutive clocks. That holds only if event pulses are at least two clocks high and two clocks low, because the smallest divisor is 4. The stimulus therefore holds `ev_in` for three clocks in each phase. It changes register values only through one-clock write strobes driven on the falling edge.

// File: rtl/ept_pkg.sv
package ept_pkg;

  localparam int CODE_W = 3;

  typedef struct packed {
    logic              force_low;
    logic              ev_mode;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Divisor per rate code; 0 means no prescaler ticks.
  function automatic logic [7:0] div_of(input logic [CODE_W-1:0] c);
    logic [7:0] d;
    case (c)
      3'd1:    d = 8'd4;
      3'd2:    d = 8'd10;
      3'd3:    d = 8'd16;
      3'd4:    d = 8'd50;
      3'd5:    d = 8'd64;
      3'd6:    d = 8'd100;
      3'd7:    d = 8'd200;
      default: d = 8'd0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ept_prescaler.sv
module ept_prescaler
  import ept_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              restart,
  output logic              tick
);

  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [PRE_W-1:0] last;

  always_comb begin
    last = PRE_W'(div_of(code)) - PRE_W'(1);
    tick = (code != '0) && (pcnt_q >= last);
    if (restart || (code == '0) || tick) pcnt_d = '0;
    else                                 pcnt_d = pcnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/ept_edge_sync.sv
module ept_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[i] <= 1'b0;
        else        sh_q[i] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[i] <= 1'b0;
        else        sh_q[i] <= sh_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ept_downcounter.sv
module ept_downcounter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load_now,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             toggle
);

  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic             irq_q, irq_d, tog_q, tog_d;

  always_comb begin
    rel_d = reload_wr ? wr_val : rel_q;
    irq_d = step && !load_now && (cnt_q == CNT_W'(1));
    cnt_d = cnt_q;
    if (load_now)   cnt_d = wr_val;
    else if (irq_d) cnt_d = rel_d;
    else if (step)  cnt_d = cnt_q - CNT_W'(1);
    tog_d = tog_q ^ irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      irq_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
      irq_q <= irq_d;
      tog_q <= tog_d;
    end
  end

  assign count  = cnt_q;
  assign irq    = irq_q;
  assign toggle = tog_q;

endmodule

// File: rtl/evt_prescale_timer.sv
module evt_prescale_timer
  import ept_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic             cpu_sel,
  input  logic [CNT_W-1:0] cpu_wdata,
  output logic [CNT_W-1:0] cpu_rdata,
  input  logic             ev_in,
  output logic             irq,
  output logic             tmr_out
);

  localparam int PAD_W = CNT_W - CTRL_W;

  logic [1:0]       rs_q;
  logic             rst_q_n;
  ctrl_t            ctrl_q, ctrl_d;
  logic             ctrl_wr, data_wr, running, restart;
  logic             tick, ev_rise, step, load_now, toggle, force_low;
  logic [CNT_W-1:0] count;

  // Reset synchroniser: asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  always_comb begin
    ctrl_wr   = cpu_we & ~cpu_sel;
    data_wr   = cpu_we &  cpu_sel;
    running   = ctrl_q.ev_mode | (ctrl_q.code != '0);
    restart   = ctrl_wr && (cpu_wdata[CODE_W-1:0] != ctrl_q.code);
    ctrl_d    = ctrl_wr ? ctrl_t'(cpu_wdata[CTRL_W-1:0]) : ctrl_q;
    step      = ctrl_q.ev_mode ? ev_rise : tick;
    load_now  = data_wr & ~running;
    force_low = ctrl_q.force_low;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  ept_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .code    (ctrl_q.code),
    .restart (restart),
    .tick    (tick)
  );

  ept_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .async_in (ev_in),
    .rise     (ev_rise)
  );

  ept_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .step      (step),
    .load_now  (load_now),
    .reload_wr (data_wr),
    .wr_val    (cpu_wdata),
    .count     (count),
    .irq       (irq),
    .toggle    (toggle)
  );

  assign tmr_out   = ~force_low & toggle;
  assign cpu_rdata = cpu_sel ? count : {{PAD_W{1'b0}}, ctrl_q};

endmodule

// File: rtl/ept_checker.sv
module ept_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             tmr_out,
  input logic             force_low,
  input logic             running,
  input logic             data_wr,
  input logic [CNT_W-1:0] count
);

  logic pv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= 1'b1;
  end

  // R6: the request never lasts more than one clock
  a_r6_irq_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: the output flips in the cycle the request shows
  a_r6_out_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && irq && !force_low && $past(!force_low)) |-> (tmr_out != $past(tmr_out)));

  // R6: the output holds when there is no underflow and no force change
  a_r6_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !irq && !force_low && $past(!force_low)) |-> $stable(tmr_out));

  // R2: a stopped timer keeps its count unless the data register is written
  a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && $past(!running) && $past(!data_wr)) |-> $stable(count));

  // R6: outside writes and reloads, the count moves only by one downward
  a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && $past(!data_wr) && !irq && (count != $past(count)))
      |-> (count == CNT_W'($past(count) - 1'b1)));

endmodule

bind evt_prescale_timer ept_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .irq       (irq),
  .tmr_out   (tmr_out),
  .force_low (force_low),
  .running   (running),
  .data_wr   (data_wr),
  .count     (count)
);

// File: tb/tb_evt_prescale_timer.sv
module tb_evt_prescale_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic       cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic       ev_in = 1'b0;
  logic [7:0] cpu_rdata;
  logic       irq;
  logic       tmr_out;

  always #4 clk = ~clk;

  evt_prescale_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_sel   (cpu_sel),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .ev_in     (ev_in),
    .irq       (irq),
    .tmr_out   (tmr_out)
  );

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } item_t;

  item_t sb[$];
  int    errors = 0;
  int    checks = 0;
  int    irq_seen = 0;

  // Counts request pulses, sampled between the rising and falling edges.
  always @(posedge clk) begin
    #2;
    if (irq === 1'b1) irq_seen++;
  end

  // Monitor: pops expected reads and compares them with the port.
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (cpu_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%0h expected=%0h", it.tag, cpu_rdata, it.exp);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = v;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic sel, input logic [7:0] exp);
    @(negedge clk);
    cpu_sel = sel;
    sb.push_back('{tag, exp});
  endtask

  task automatic pulse();
    @(negedge clk); ev_in = 1'b1;
    idle(3);
    ev_in = 1'b0;
    idle(3);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    int tog;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 tmr_out", int'(tmr_out), 0);
    chk("R1 irq", int'(irq), 0);
    rd("R1 ctrl", 1'b0, 8'h00);
    rd("R1 count", 1'b1, 8'h00);

    // R5 stopped data write loads the count
    wr(1'b1, 8'd5);
    rd("R5 stopped load", 1'b1, 8'd5);

    // R2 each divisor: one step at d clocks, the second exactly at 2d
    for (int c = 1; c <= 7; c++) begin
      int d;
      case (c)
        1: d = 4;   2: d = 10;  3: d = 16;  4: d = 50;
        5: d = 64;  6: d = 100; default: d = 200;
      endcase
      wr(1'b0, 8'h00);
      wr(1'b1, 8'd9);
      wr(1'b0, 8'(c));
      idle(2 * d - 2);
      rd($sformatf("R2 code %0d before 2nd step", c), 1'b1, 8'd8);
      rd($sformatf("R2 code %0d at 2nd step", c), 1'b1, 8'd7);
    end

    // R2 code 0 holds the count
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h21);
    base = irq_seen;
    idle(50);
    rd("R2 stopped hold", 1'b1, 8'h21);
    chk("R2 stopped no irq", irq_seen - base, 0);

    // R6 underflow: reload 3, divide by 4, underflow at clock 12
    wr(1'b1, 8'd3);
    base = irq_seen;
    tog  = int'(tmr_out);
    wr(1'b0, 8'h01);
    idle(20);
    chk("R6 one irq pulse", irq_seen - base, 1);
    chk("R6 output toggled", int'(tmr_out), 1 - tog);
    rd("R6 reloaded then stepped", 1'b1, 8'd1);

    // R4 force low, toggle continues underneath
    wr(1'b0, 8'h11);
    chk("R4 forced low", int'(tmr_out), 0);
    rd("R9 ctrl readback", 1'b0, 8'h11);
    idle(10);
    chk("R4 still low", int'(tmr_out), 0);
    wr(1'b0, 8'h00);
    chk("R4 parity on release", int'(tmr_out), irq_seen % 2);

    // R5 running write changes only the reload value
    wr(1'b1, 8'd3);
    wr(1'b0, 8'h01);
    wr(1'b1, 8'd7);
    rd("R5 running write keeps count", 1'b1, 8'd3);
    idle(9);
    rd("R5 new reload used", 1'b1, 8'd7);

    // R8 code change restarts the prescaler
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd9);
    wr(1'b0, 8'h01);
    idle(8);
    wr(1'b0, 8'h03);
    idle(14);
    rd("R8 no step before full period", 1'b1, 8'd7);
    rd("R8 step after full period", 1'b1, 8'd6);

    // R7 reload 0 gives 256 steps
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    base = irq_seen;
    wr(1'b0, 8'h01);
    idle(1022);
    chk("R7 no irq before step 256", irq_seen - base, 0);
    rd("R7 count after 255 steps", 1'b1, 8'd1);
    idle(1);
    chk("R7 irq at step 256", irq_seen - base, 1);
    rd("R7 reload 0", 1'b1, 8'd0);

    // R3 event mode; R9 upper control bits dropped
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd4);
    wr(1'b0, 8'hE9);
    rd("R9 upper bits dropped", 1'b0, 8'h09);
    idle(40);
    rd("R3 prescaler ignored", 1'b1, 8'd4);
    pulse(); pulse(); pulse();
    idle(5);
    rd("R3 three edges", 1'b1, 8'd1);
    base = irq_seen;
    pulse();
    idle(5);
    chk("R3 underflow on edge", irq_seen - base, 1);
    rd("R3 reload after edge", 1'b1, 8'd4);

    wr(1'b0, 8'h00);
    idle(3);
    summary();
    $finish;
  end

endmodule